// File: doc/BRIEF.md
# XMODEM-1K CRC Boot Receiver

This block receives a boot image over a serial byte link using XMODEM with CRC-16 checking, in both the 128-byte and the 1 KiB packet forms. A UART receiver in front of it supplies one byte per valid pulse, with a flag that marks a parity failure. The block sends its single-byte replies (start requests, acknowledgements and negative acknowledgements) to a UART transmitter over a valid/ready pair. It writes payload bytes to a byte-wide memory port at incrementing addresses.

At boot the block keeps inviting the host with the CRC start request at a fixed interval, up to a fixed number of times. Once packets flow, it frames each one, checks the block number against its complement, checks the sequence, verifies the CRC and watches the spacing between bytes. It acknowledges good packets and asks for damaged ones again. It ends in one of three terminal states: done on end of transfer, timeout when the host is silent too long, or error on a sequence fault or too many retries.

Payload bytes go to memory as they arrive. The image length, `byte_count`, moves forward only when a packet passes every check. A rejected packet's bytes therefore sit past the committed image, and the retransmission overwrites them.

Top module: `xmr_rx_ctrl`

## Requirements
- R1: While reset is held, tx_valid, mem_we, done, timeout and error are low and byte_count is 0. The first reply after reset is the start request 0x43.
- R2: Before any header arrives, the start request 0x43 repeats every PING_IV cycles, PING_COUNT times in all. If no header has arrived one interval after the last request, timeout rises.
- R3: A header byte 0x01 opens a 128-byte packet and 0x02 opens a 1024-byte packet. The header is followed by the block number, its ones' complement, the payload, and then the CRC high byte and CRC low byte.
- R4: The CRC is the 0x1021 polynomial with a zero start value, fed most significant bit first over the payload only. On a mismatch the block replies 0x15 and byte_count is unchanged.
- R5: A correct packet carrying the expected block number (1 first, then incrementing modulo 256) gets reply 0x06. Its payload goes to addresses byte_count onward in order, and byte_count then grows by the packet length.
- R6: If the complement byte is not the ones' complement of the block number, the reply is 0x15.
- R7: A parity error on any byte of a packet makes the reply 0x15, even when the CRC matches.
- R8: If more than GAP_LIMIT cycles pass between two bytes of a packet, the partial packet is dropped, the reply is 0x15 and byte_count is unchanged.
- R9: A correct repeat of the last accepted block gets reply 0x06, causes no memory write and leaves byte_count unchanged.
- R10: A correct packet with any other block number raises error and sends no reply.
- R11: The MAX_NAK-th consecutive 0x15 for one block is sent and error then rises. With one fewer, error stays low.
- R12: After the first header, if no new header arrives within IDLE_LIMIT cycles while waiting between packets, timeout rises.
- R13: The end-of-transfer byte 0x04 gets reply 0x06 and raises done, and byte_count then holds the image length. At most one of done, timeout and error is high, and each stays high until reset.
- R14: A reply stays on tx_data with tx_valid high, unchanged, until tx_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity failure on the received byte |
| tx_valid | output | 1 | Reply byte offered to the transmitter |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| mem_we | output | 1 | Payload byte write strobe |
| mem_addr | output | AW | Payload byte address |
| mem_wdata | output | 8 | Payload byte |
| done | output | 1 | Transfer ended normally |
| timeout | output | 1 | Host silent too long |
| error | output | 1 | Sequence fault or retry limit reached |
| byte_count | output | AW | Committed image length in bytes |

## Verification
A reply is offered on tx_valid one cycle after the edge that takes the packet's last CRC byte, or the end-of-transfer byte. It is logged on the following edge, so the bench waits three cycles after its last byte before it compares the reply log. A memory write appears one cycle after each payload byte. byte_count changes on the same edge that queues the acknowledgement, so it is read together with the reply. The ping, idle and gap limits count from about two cycles after the triggering event. The bench therefore checks each timeout twice, 20 cycles before its nominal expiry and 20 cycles after it, and measures the ping spacing exactly, edge to edge, between two later requests.

// File: rtl/xmr_pkg.sv
`timescale 1ns/1ps
package xmr_pkg;
  typedef enum logic [3:0] {
    ST_BOOT, ST_HDR, ST_BLK, ST_NBLK, ST_DATA, ST_CRCH, ST_CRCL,
    ST_DONE, ST_TMO, ST_ERR
  } xmr_state_e;

  localparam logic [7:0] CODE_SOH = 8'h01;
  localparam logic [7:0] CODE_STX = 8'h02;
  localparam logic [7:0] CODE_EOT = 8'h04;
  localparam logic [7:0] CODE_ACK = 8'h06;
  localparam logic [7:0] CODE_NAK = 8'h15;
  localparam logic [7:0] CODE_CRQ = 8'h43;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  // One byte into the CRC register, bit-serial, MSB of the data first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction
endpackage

// File: rtl/xmr_crc16.sv
`timescale 1ns/1ps
module xmr_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import xmr_pkg::*;
  always_ff @(posedge clk) begin
    if (!rst_n || init) crc <= 16'h0000;
    else if (upd)       crc <= crc16_step(crc, din);
  end
endmodule

// File: rtl/xmr_interval.sv
`timescale 1ns/1ps
module xmr_interval #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;
  assign hit = en && !clr && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !en || hit) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  // R8: an expiry restarts the count, so two expiries never touch
  a_r8_hit_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/xmr_reply.sv
`timescale 1ns/1ps
module xmr_reply (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [7:0] req_byte,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready
);
  logic stalled;
  assign stalled = tx_valid && !tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else if (req && !stalled) begin
      tx_valid <= 1'b1;
      tx_data  <= req_byte;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  a_r14_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> tx_valid && $stable(tx_data));
endmodule

// File: rtl/xmr_rx_ctrl.sv
`timescale 1ns/1ps
module xmr_rx_ctrl #(
  parameter int unsigned AW         = 20,
  parameter int unsigned PING_COUNT = 10,
  parameter int unsigned PING_IV    = 37_500_000,
  parameter int unsigned IDLE_LIMIT = 375_000_000,
  parameter int unsigned GAP_LIMIT  = 250_000,
  parameter int unsigned MAX_NAK    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_par_err,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          done,
  output logic          timeout,
  output logic          error,
  output logic [AW-1:0] byte_count
);
  import xmr_pkg::*;

  localparam int unsigned TMAX0 = (PING_IV > GAP_LIMIT) ? PING_IV : GAP_LIMIT;
  localparam int unsigned TMAX  = (IDLE_LIMIT > TMAX0) ? IDLE_LIMIT : TMAX0;
  localparam int unsigned TW    = $clog2(TMAX + 1);
  localparam int unsigned PCW   = $clog2(PING_COUNT + 1);
  localparam int unsigned NCW   = $clog2(MAX_NAK + 1);

  xmr_state_e     state, st_prev;
  logic           started, big, blk_ok, wr_ok, perr;
  logic [PCW-1:0] ping_cnt;
  logic [NCW-1:0] nak_cnt;
  logic [7:0]     exp_blk, blk, rcv_hi, rq_byte;
  logic [9:0]     idx;
  logic [AW-1:0]  base;
  logic           rq;
  logic [15:0]    crc;

  // Named internal events
  logic          in_pkt, tmr_en, tmr_clr, tmr_hit, ev_hdr, ev_pkt_end;
  logic          pkt_bad, ev_gap, ev_fail, is_new, is_dup, crc_ok;
  logic [TW-1:0] tmr_lim;
  logic [9:0]    len_m1;

  assign in_pkt  = (state == ST_BLK) || (state == ST_NBLK) || (state == ST_DATA) ||
                   (state == ST_CRCH) || (state == ST_CRCL);
  assign tmr_en  = in_pkt || (state == ST_HDR);
  assign tmr_clr = (state != st_prev) || (rx_valid && in_pkt);
  assign tmr_lim = in_pkt ? TW'(GAP_LIMIT) : (started ? TW'(IDLE_LIMIT) : TW'(PING_IV));
  assign len_m1  = big ? 10'd1023 : 10'd127;
  assign ev_hdr  = (state == ST_HDR) && rx_valid && !rx_par_err && !tmr_hit &&
                   ((rx_data == CODE_SOH) || (rx_data == CODE_STX));
  assign crc_ok     = ({rcv_hi, rx_data} == crc);
  assign ev_pkt_end = (state == ST_CRCL) && rx_valid;
  assign pkt_bad    = perr || rx_par_err || !blk_ok || !crc_ok;
  assign ev_gap     = in_pkt && tmr_hit;
  assign ev_fail    = ev_gap || (ev_pkt_end && pkt_bad);
  assign is_new     = (blk == exp_blk);
  assign is_dup     = (blk == exp_blk - 8'd1) && (base != '0);

  xmr_interval #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .clr(tmr_clr), .limit(tmr_lim), .hit(tmr_hit)
  );

  xmr_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(ev_hdr),
    .upd((state == ST_DATA) && rx_valid), .din(rx_data), .crc(crc)
  );

  xmr_reply u_rep (
    .clk(clk), .rst_n(rst_n), .req(rq), .req_byte(rq_byte),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_BOOT;  st_prev <= ST_BOOT;
      started <= 1'b0;   big <= 1'b0;   blk_ok <= 1'b0;  wr_ok <= 1'b0;
      perr <= 1'b0;      ping_cnt <= '0; nak_cnt <= '0;
      exp_blk <= 8'd1;   blk <= 8'd0;   rcv_hi <= 8'd0;  idx <= '0;
      base <= '0;        rq <= 1'b0;    rq_byte <= 8'h00;
      mem_we <= 1'b0;    mem_addr <= '0; mem_wdata <= 8'h00;
    end else begin
      rq      <= 1'b0;
      mem_we  <= 1'b0;
      st_prev <= state;
      case (state)
        ST_BOOT: begin
          rq <= 1'b1;  rq_byte <= CODE_CRQ;  ping_cnt <= PCW'(1);
          state <= ST_HDR;
        end
        ST_HDR: begin
          if (tmr_hit) begin
            if (started || ping_cnt == PCW'(PING_COUNT)) state <= ST_TMO;
            else begin
              rq <= 1'b1;  rq_byte <= CODE_CRQ;  ping_cnt <= ping_cnt + 1'b1;
            end
          end else if (ev_hdr) begin
            big <= (rx_data == CODE_STX);  started <= 1'b1;  perr <= 1'b0;
            state <= ST_BLK;
          end else if (rx_valid && !rx_par_err && rx_data == CODE_EOT) begin
            rq <= 1'b1;  rq_byte <= CODE_ACK;  state <= ST_DONE;
          end
        end
        ST_BLK: if (rx_valid) begin
          blk <= rx_data;  perr <= perr | rx_par_err;  state <= ST_NBLK;
        end
        ST_NBLK: if (rx_valid) begin
          blk_ok <= (rx_data == ~blk);
          wr_ok  <= (rx_data == ~blk) && (blk == exp_blk);
          perr   <= perr | rx_par_err;  idx <= '0;  state <= ST_DATA;
        end
        ST_DATA: if (rx_valid) begin
          perr <= perr | rx_par_err;
          if (wr_ok) begin
            mem_we <= 1'b1;  mem_addr <= base + AW'(idx);  mem_wdata <= rx_data;
          end
          idx <= idx + 1'b1;
          if (idx == len_m1) state <= ST_CRCH;
        end
        ST_CRCH: if (rx_valid) begin
          rcv_hi <= rx_data;  perr <= perr | rx_par_err;  state <= ST_CRCL;
        end
        ST_CRCL: if (rx_valid && !pkt_bad) begin
          if (is_new) begin
            rq <= 1'b1;  rq_byte <= CODE_ACK;  nak_cnt <= '0;
            base <= base + (big ? AW'(1024) : AW'(128));
            exp_blk <= exp_blk + 8'd1;  state <= ST_HDR;
          end else if (is_dup) begin
            rq <= 1'b1;  rq_byte <= CODE_ACK;  nak_cnt <= '0;  state <= ST_HDR;
          end else begin
            state <= ST_ERR;
          end
        end
        default: ;
      endcase
      if (ev_fail) begin
        rq <= 1'b1;  rq_byte <= CODE_NAK;  nak_cnt <= nak_cnt + 1'b1;
        state <= (nak_cnt == NCW'(MAX_NAK - 1)) ? ST_ERR : ST_HDR;
      end
    end
  end

  assign done       = (state == ST_DONE);
  assign timeout    = (state == ST_TMO);
  assign error      = (state == ST_ERR);
  assign byte_count = base;

  a_r13_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout, error}));
  a_r13_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout || error) |=> $stable({done, timeout, error}));
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_count != $past(byte_count)) |->
      ((byte_count - $past(byte_count)) == AW'(128) ||
       (byte_count - $past(byte_count)) == AW'(1024)));
  a_r5_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= byte_count) && (mem_addr - byte_count < AW'(1024)));
  a_r2_ping_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ping_cnt <= PCW'(PING_COUNT));
  a_r11_nak_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_cnt == NCW'(MAX_NAK)) |-> error);
endmodule

// File: tb/tb_xmr_rx_ctrl.sv
`timescale 1ns/1ps
module tb_xmr_rx_ctrl;
  localparam int AW = 12;
  localparam int PING_COUNT = 10;
  localparam int PING_IV = 300;
  localparam int IDLE_LIMIT = 3000;
  localparam int GAP_LIMIT = 50;
  localparam int MAX_NAK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_par_err = 1'b0;
  logic tx_valid, tx_ready = 1'b1;
  logic [7:0] tx_data;
  logic mem_we;
  logic [AW-1:0] mem_addr, byte_count;
  logic [7:0] mem_wdata;
  logic done, timeout, error;

  always #4 clk = ~clk;

  xmr_rx_ctrl #(.AW(AW), .PING_COUNT(PING_COUNT), .PING_IV(PING_IV),
    .IDLE_LIMIT(IDLE_LIMIT), .GAP_LIMIT(GAP_LIMIT), .MAX_NAK(MAX_NAK)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .done(done), .timeout(timeout), .error(error),
    .byte_count(byte_count));

  int checks = 0, fails = 0;
  int cyc = 0, tx_n = 0, wr_cnt = 0;
  logic [7:0] tx_log [0:255];
  int tx_t [0:255];
  logic [7:0] mem [0:(1<<AW)-1];
  logic [7:0] img [0:(1<<AW)-1];
  logic [7:0] pay [0:1023];
  int img_len = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && tx_valid && tx_ready) begin
      tx_log[tx_n[7:0]] <= tx_data;
      tx_t[tx_n[7:0]] <= cyc;
      tx_n <= tx_n + 1;
    end
    if (rst_n && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
    summary();
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Bench CRC: register-wide XOR of the byte, then eight shift/reduce steps
  function automatic logic [15:0] tb_crc(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      c = c ^ {pay[i], 8'h00};
      for (int k = 0; k < 8; k++)
        c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b, input bit pe);
    rx_valid = 1'b1; rx_data = b; rx_par_err = pe;
    @(negedge clk);
    rx_valid = 1'b0; rx_par_err = 1'b0;
    tick($urandom % 3);
  endtask

  // stop_at >= 0: go silent after that many payload bytes
  task automatic send_pkt(input bit big, input logic [7:0] blk, input logic [7:0] nblk,
                          input bit flip, input int pe_idx, input int stop_at, input bit fresh);
    int n = big ? 1024 : 128;
    logic [15:0] c;
    if (fresh) for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
    c = tb_crc(n) ^ (flip ? 16'h0001 : 16'h0000);
    put(big ? 8'h02 : 8'h01, 1'b0);
    put(blk, 1'b0);
    put(nblk, 1'b0);
    for (int i = 0; i < n; i++) begin
      if (i == stop_at) begin tick(GAP_LIMIT + 10); return; end
      put(pay[i], i == pe_idx);
    end
    put(c[15:8], 1'b0);
    put(c[7:0], 1'b0);
  endtask

  task automatic commit_img(input int n);
    for (int i = 0; i < n; i++) img[img_len + i] = pay[i];
    img_len += n;
  endtask

  task automatic expect_reply(input logic [7:0] exp, input int seen, input string tag);
    tick(3);
    check(tx_n == seen + 1 && tx_log[seen[7:0]] == exp, tag,
          (tx_n == seen + 1) ? int'(tx_log[seen[7:0]]) : 32'hFFFF, int'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    img_len = 0;
    rst_n = 1'b1;
  endtask

  int seen, w0, t0;
  bit ok;

  initial begin
    void'($urandom(32'h1EEDF00D));
    tick(2);
    // R1: reset values
    check(!tx_valid && !mem_we && !done && !timeout && !error && byte_count == 0,
          "R1 reset outputs", {tx_valid, mem_we, done, timeout, error}, 0);
    seen = tx_n;
    rst_n = 1'b1;
    expect_reply(8'h43, seen, "R1 first start request");

    // R2: exact spacing between later start requests
    while (tx_n < 3) tick(1);
    check(tx_t[2] - tx_t[1] == PING_IV, "R2 ping spacing", tx_t[2] - tx_t[1], PING_IV);

    // R3 R5: good 1 KiB packet, block 1
    seen = tx_n;
    send_pkt(1'b1, 8'd1, 8'hFE, 1'b0, -1, -1, 1'b1);
    commit_img(1024);
    expect_reply(8'h06, seen, "R3 R5 1K packet ack");
    check(byte_count == 1024, "R5 count after 1K", byte_count, 1024);

    // R4: CRC mismatch
    seen = tx_n;
    send_pkt(1'b0, 8'd2, 8'hFD, 1'b1, -1, -1, 1'b1);
    expect_reply(8'h15, seen, "R4 bad crc nak");
    check(byte_count == 1024, "R4 count held", byte_count, 1024);
    seen = tx_n;
    send_pkt(1'b0, 8'd2, 8'hFD, 1'b0, -1, -1, 1'b0);
    commit_img(128);
    expect_reply(8'h06, seen, "R3 R5 128 packet ack");
    check(byte_count == 1152, "R5 count after 128", byte_count, 1152);

    // R9: duplicate of block 2
    seen = tx_n; w0 = wr_cnt;
    send_pkt(1'b0, 8'd2, 8'hFD, 1'b0, -1, -1, 1'b1);
    expect_reply(8'h06, seen, "R9 duplicate ack");
    check(wr_cnt == w0, "R9 no write on duplicate", wr_cnt - w0, 0);
    check(byte_count == 1152, "R9 count held", byte_count, 1152);

    // R6: complement mismatch
    seen = tx_n;
    send_pkt(1'b0, 8'd3, 8'hFD, 1'b0, -1, -1, 1'b1);
    expect_reply(8'h15, seen, "R6 complement nak");

    // R7: parity error inside the payload
    seen = tx_n;
    send_pkt(1'b0, 8'd3, 8'hFC, 1'b0, 17 + ($urandom % 100), -1, 1'b1);
    expect_reply(8'h15, seen, "R7 parity nak");

    // R8: gap inside a packet
    seen = tx_n;
    send_pkt(1'b0, 8'd3, 8'hFC, 1'b0, -1, 20, 1'b1);
    check(tx_n == seen + 1 && tx_log[seen[7:0]] == 8'h15, "R8 gap nak",
          int'(tx_log[seen[7:0]]), 8'h15);
    check(byte_count == 1152, "R8 count held", byte_count, 1152);

    // R14: stalled transmitter, then good block 3
    tx_ready = 1'b0;
    seen = tx_n;
    send_pkt(1'b0, 8'd3, 8'hFC, 1'b0, -1, -1, 1'b1);
    commit_img(128);
    tick(6);
    check(tx_valid && tx_data == 8'h06 && tx_n == seen, "R14 reply held",
          {tx_valid, tx_data}, {1'b1, 8'h06});
    tx_ready = 1'b1;
    tick(2);
    check(tx_n == seen + 1 && tx_log[seen[7:0]] == 8'h06, "R14 reply released",
          int'(tx_log[seen[7:0]]), 8'h06);

    // R13: end of transfer and image contents
    seen = tx_n;
    put(8'h04, 1'b0);
    expect_reply(8'h06, seen, "R13 eot ack");
    check(done && !timeout && !error && byte_count == 1280, "R13 done and length",
          {done, byte_count}, {1'b1, 12'd1280});
    ok = 1'b1;
    for (int i = 0; i < img_len; i++) if (mem[i] != img[i]) ok = 1'b0;
    check(ok, "R5 image contents", ok, 1);
    tick(20);
    check(done, "R13 done sticky", done, 1);

    // R2: no host at all
    do_reset();
    t0 = cyc;
    seen = tx_n;
    tick(PING_COUNT * PING_IV - 20);
    check(!timeout, "R2 no early timeout", timeout, 0);
    tick(40);
    check(timeout && tx_n == seen + PING_COUNT, "R2 timeout after pings",
          tx_n - seen, PING_COUNT);
    ok = 1'b1;
    for (int i = seen; i < tx_n; i++) if (tx_log[i[7:0]] != 8'h43) ok = 1'b0;
    check(ok, "R2 every ping is 0x43", ok, 1);

    // R12: idle after first packet
    do_reset();
    tick(5);
    seen = tx_n;
    send_pkt(1'b0, 8'd1, 8'hFE, 1'b0, -1, -1, 1'b1);
    tick(IDLE_LIMIT - 20);
    check(!timeout, "R12 no early idle timeout", timeout, 0);
    tick(40);
    check(timeout && !error, "R12 idle timeout", timeout, 1);

    // R10: out-of-order block
    do_reset();
    tick(5);
    send_pkt(1'b0, 8'd1, 8'hFE, 1'b0, -1, -1, 1'b1);
    tick(3);
    seen = tx_n;
    send_pkt(1'b0, 8'd5, 8'hFA, 1'b0, -1, -1, 1'b1);
    tick(4);
    check(error && tx_n == seen, "R10 sequence error, no reply", {error, 8'(tx_n - seen)}, 9'h100);

    // R11: retry limit
    do_reset();
    tick(5);
    seen = tx_n;
    for (int k = 0; k < MAX_NAK - 1; k++) send_pkt(1'b0, 8'd1, 8'hFE, 1'b1, -1, -1, 1'b1);
    tick(3);
    check(!error && tx_n == seen + MAX_NAK - 1, "R11 below limit", tx_n - seen, MAX_NAK - 1);
    send_pkt(1'b0, 8'd1, 8'hFE, 1'b1, -1, -1, 1'b1);
    tick(3);
    check(error && tx_n == seen + MAX_NAK && tx_log[8'(tx_n - 1)] == 8'h15,
          "R11 error after last nak", tx_n - seen, MAX_NAK);

    summary();
  end
endmodule